// File: doc/BRIEF.md
# Two-Wire Output Port Expander Slave

This block is a two-wire serial bus slave that owns one 8-bit output register and reports the real levels on its output pins. It samples SCL and SDA with the system clock through two-flop synchronizers. From the synchronized lines it detects START, repeated START and STOP. It then decodes a 7-bit address, acknowledges bytes and drives SDA through an open-drain pull-low enable. The address has a fixed upper part and a lower part that arrives on an input from external address-select logic.

There is no register pointer. A written byte always replaces all eight outputs at once. A read byte is always a fresh capture of the sensed pin levels, so a pin that is held against its programmed value reads back as it actually is. A power-on reset loads the outputs from a power-up default input. A separate active-low bus clear abandons any transfer and leaves the outputs unchanged.

Top module: `i2c_out_expander`

## Requirements
- R1: While `rst_ni` is low and after it rises, `port_o` equals `pwrup_val_i` and `sda_pull_o` is 0, until the first written byte.
- R2: The slave acknowledges an address byte only when its upper seven bits equal {3'b101, `addr_lo_i`}. The acknowledge means `sda_pull_o` is high through the high phase of the ninth SCL clock. The last bit of the address byte is R/W, with 0 meaning write and 1 meaning read.
- R3: In a write, the slave acknowledges every data byte. Each byte replaces all 8 bits of `port_o` by the end of its acknowledge clock, and this repeats for every further byte until STOP.
- R4: In a read, the first byte is the `pin_sense_i` value captured during the address acknowledge clock. It is sent MSB first, with bit 7 matching pin 7, and later pin changes do not alter it.
- R5: Each master ACK (SDA low on the ninth clock of a read byte) captures `pin_sense_i` again for the next byte. The byte reflects the sensed pins even when they differ from `port_o`.
- R6: After a master NACK on a read byte, the slave releases SDA and does not pull it low again until a START.
- R7: After an address mismatch, the slave ignores all clocks until the next START or STOP: it gives no acknowledge and `port_o` does not change.
- R8: A repeated START during a transfer restarts address reception, so a read can follow a write without a STOP.
- R9: A low on `bus_clear_ni` abandons the transfer and releases SDA on the next cycle. It leaves `port_o` unchanged, and a new transfer afterwards works normally.
- R10: `sda_pull_o` rises only while the synchronized SCL is low.

Verification below: see section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| bus_clear_ni | input | 1 | Synchronous bus-interface clear, active low |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| addr_lo_i | input | 4 | Variable low address bits |
| pwrup_val_i | input | 8 | Output value loaded at power-on reset |
| port_o | output | 8 | Output register driving the pins |
| pin_sense_i | input | 8 | Sensed pin levels returned on reads |

## Verification
A wrong bit counter or an early acknowledge shows up within one byte time as a missing or shifted acknowledge on SDA, or as a write value rotated by one bit in `port_o`. A snapshot taken at the wrong point is caught by changing the sensed pins just after each acknowledge clock; the byte read then shows the new value where the old one is expected. A slave stuck in the wrong state after a NACK, a mismatch or a bus clear shows as SDA pulled low on the following clocks, or as `port_o` changing on data it should ignore.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } state_e;
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2cx_bus_mon.sv
module i2cx_bus_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] line_raw, line_s;
  logic       scl_q, sda_q;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2cx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_s[g])
    );
  end

  assign scl_s_o = line_s[1];
  assign sda_s_o = line_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_o;
      sda_q <= sda_s_o;
    end
  end

  assign scl_rise_o = !scl_q && scl_s_o;
  assign scl_fall_o = scl_q && !scl_s_o;
  // SDA edges qualify only when SCL stayed high across both samples
  assign start_o    = scl_q && scl_s_o && sda_q && !sda_s_o;
  assign stop_o     = scl_q && scl_s_o && !sda_q && sda_s_o;
endmodule

// File: rtl/i2cx_ctrl.sv
module i2cx_ctrl
  import i2cx_pkg::*;
#(
  parameter int                SUB_W     = 4,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_clear_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SUB_W-1:0]  addr_lo_i,
  input  logic [BYTE_W-1:0] pins_i,
  output logic              sda_pull_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output state_e            state_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  state_e             state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  sh_q;
  logic               full_q, rw_q, pull_q;
  logic [ADDR_W-1:0]  my_addr;

  assign my_addr = {ADDR_BASE[ADDR_W-1:SUB_W], addr_lo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      full_q  <= 1'b0;
      rw_q    <= 1'b0;
      pull_q  <= 1'b0;
    end else if (!bus_clear_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      full_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) full_q <= 1'b1;
          end else if (scl_fall_i && full_q) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
            if (state_q == ST_WDATA) begin
              pull_q  <= 1'b1;
              state_q <= ST_WACK;
            end else if (sh_q[BYTE_W-1:1] == my_addr) begin
              pull_q  <= 1'b1;
              rw_q    <= sh_q[0];
              state_q <= ST_AACK;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        ST_AACK: begin
          if (scl_rise_i && rw_q) begin
            sh_q <= pins_i;
          end else if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              pull_q  <= !sh_q[BYTE_W-1];
              state_q <= ST_RDATA;
            end else begin
              pull_q  <= 1'b0;
              state_q <= ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall_i) begin
            pull_q  <= 1'b0;
            state_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall_i) begin
            if (cnt_q == LAST) begin
              pull_q  <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_RACK;
            end else begin
              sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
              pull_q <= !sh_q[BYTE_W-2];
              cnt_q  <= cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            if (!sda_s_i) sh_q    <= pins_i;
            else          state_q <= ST_IGNORE;
          end else if (scl_fall_i) begin
            cnt_q   <= '0;
            pull_q  <= !sh_q[BYTE_W-1];
            state_q <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  // start/stop need SCL high on both samples, so they never meet scl_fall
  assign wr_stb_o   = bus_clear_ni && (state_q == ST_WDATA) && scl_fall_i && full_q;
  assign wr_data_o  = sh_q;
  assign sda_pull_o = pull_q;
  assign state_o    = state_q;
endmodule

// File: rtl/i2cx_port_reg.sv
module i2cx_port_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pwrup_i,
  input  logic         stb_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= pwrup_i;
    else if (stb_i) q_o <= d_i;
  end
endmodule

// File: rtl/i2c_out_expander.sv
module i2c_out_expander
  import i2cx_pkg::*;
#(
  parameter int                SUB_W       = 4,
  parameter logic [ADDR_W-1:0] ADDR_BASE   = 7'h50,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_clear_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [SUB_W-1:0]  addr_lo_i,
  input  logic [BYTE_W-1:0] pwrup_val_i,
  output logic [BYTE_W-1:0] port_o,
  input  logic [BYTE_W-1:0] pin_sense_i
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_data;
  state_e            state;

  i2cx_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) mon_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s_o   (scl_s),
    .sda_s_o   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  i2cx_ctrl #(.SUB_W(SUB_W), .ADDR_BASE(ADDR_BASE)) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_clear_ni(bus_clear_ni),
    .sda_s_i     (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_ev),
    .stop_i      (stop_ev),
    .addr_lo_i   (addr_lo_i),
    .pins_i      (pin_sense_i),
    .sda_pull_o  (sda_pull_o),
    .wr_stb_o    (wr_stb),
    .wr_data_o   (wr_data),
    .state_o     (state)
  );

  i2cx_port_reg #(.W(BYTE_W)) preg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwrup_i(pwrup_val_i),
    .stb_i  (wr_stb),
    .d_i    (wr_data),
    .q_o    (port_o)
  );
endmodule

// File: rtl/i2cx_chk.sv
module i2cx_chk
  import i2cx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_clear_ni,
  input logic              scl_s,
  input logic              sda_pull_o,
  input logic [BYTE_W-1:0] port_o,
  input logic              wr_stb,
  input state_e            state
);
  // R10
  pull_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_s);

  // R9
  clear_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_clear_ni |=> !sda_pull_o);

  // R9
  clear_keeps_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_clear_ni |=> $stable(port_o));

  // R6
  ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGNORE) |-> !sda_pull_o);

  // R3
  port_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(port_o) |-> $past(wr_stb));

  // R7
  ignore_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGNORE) |-> !wr_stb);
endmodule

bind i2c_out_expander i2cx_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_clear_ni(bus_clear_ni),
  .scl_s       (scl_s),
  .sda_pull_o  (sda_pull_o),
  .port_o      (port_o),
  .wr_stb      (wr_stb),
  .state       (state)
);

// File: tb/i2c_out_expander_tb_top.sv
`timescale 1ns/1ps
module i2c_out_expander_tb_top;
  localparam int T = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_clear_n = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       pull;
  logic       sda_line;
  logic [3:0] addr_lo = 4'h6;
  logic [7:0] pwrup = 8'hF0;
  logic [7:0] port;
  logic [7:0] fmask = 8'h00;
  logic [7:0] pins;

  int checks = 0;
  int fails  = 0;
  int pull_viol = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~pull;
  assign pins     = port ^ fmask;

  i2c_out_expander dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_clear_ni(bus_clear_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_pull_o  (pull),
    .addr_lo_i   (addr_lo),
    .pwrup_val_i (pwrup),
    .port_o      (port),
    .pin_sense_i (pins)
  );

  // R10: pull may only go active while the raw SCL has been low
  logic pull_d = 1'b0;
  always @(posedge clk) begin
    if (pull && !pull_d && scl) pull_viol++;
    pull_d <= pull;
  end

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wait_c(T);
    scl = 1'b1;   wait_c(T);
    sda_m = 1'b0; wait_c(T);
    scl = 1'b0;   wait_c(2);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_c(T);
    scl = 1'b1;   wait_c(T);
    sda_m = 1'b1; wait_c(T);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b;   wait_c(T);
    scl = 1'b1;  wait_c(T/2);
    seen = sda_line;
    wait_c(T/2);
    scl = 1'b0;  wait_c(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(mack, s);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check(port == 8'hF0, "R1 port after reset", port, 8'hF0);
    check(pull == 1'b0, "R1 sda released after reset", {7'd0, pull}, 8'h00);
  endtask

  task automatic t_write();
    logic a;
    i2c_start();
    send_byte({3'b101, 4'h6, 1'b0}, a);
    check(a == 1'b0, "R2 address ack", {7'd0, a}, 8'h00);
    send_byte(8'h5A, a);
    check(a == 1'b0, "R3 data ack", {7'd0, a}, 8'h00);
    check(port == 8'h5A, "R3 first byte", port, 8'h5A);
    send_byte(8'hA5, a);
    check(port == 8'hA5, "R3 second byte", port, 8'hA5);
    send_byte(8'h3C, a);
    check(a == 1'b0 && port == 8'h3C, "R3 third byte", port, 8'h3C);
    i2c_stop();
  endtask

  task automatic t_wrong_addr();
    logic a;
    i2c_start();
    send_byte({3'b101, 4'h9, 1'b0}, a);
    check(a == 1'b1, "R2 mismatch not acked", {7'd0, a}, 8'h01);
    send_byte(8'hFF, a);
    check(a == 1'b1, "R7 no ack while ignoring", {7'd0, a}, 8'h01);
    check(port == 8'h3C, "R7 port unchanged", port, 8'h3C);
    i2c_stop();
    // wrong fixed part R/W=1: also ignored
    i2c_start();
    send_byte({3'b110, 4'h6, 1'b1}, a);
    check(a == 1'b1, "R2 fixed bits mismatch", {7'd0, a}, 8'h01);
    i2c_stop();
  endtask

  task automatic t_read_snap();
    logic a;
    logic [7:0] b;
    int lows = 0;
    logic s;
    fmask = 8'h00;
    i2c_start();
    send_byte({3'b101, 4'h6, 1'b1}, a);
    check(a == 1'b0, "R2 read address ack", {7'd0, a}, 8'h00);
    fmask = 8'h81;  // after the snapshot
    recv_byte(b, 1'b0);
    check(b == 8'h3C, "R4 first byte is address-ack snapshot", b, 8'h3C);
    fmask = 8'h3C;  // after the master-ack snapshot
    recv_byte(b, 1'b1);
    check(b == 8'hBD, "R5 second byte is sensed pins", b, 8'hBD);
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      if (!s) lows++;
    end
    check(lows == 0, "R6 sda released after NACK", 8'(lows), 8'h00);
    i2c_stop();
    fmask = 8'h00;
  endtask

  task automatic t_rstart();
    logic a;
    logic [7:0] b;
    i2c_start();
    send_byte({3'b101, 4'h6, 1'b0}, a);
    send_byte(8'h11, a);
    i2c_start();
    send_byte({3'b101, 4'h6, 1'b1}, a);
    check(a == 1'b0, "R8 ack after repeated start", {7'd0, a}, 8'h00);
    recv_byte(b, 1'b1);
    check(b == 8'h11, "R8 read after repeated start", b, 8'h11);
    i2c_stop();
  endtask

  task automatic t_bus_clear();
    logic a, s;
    i2c_start();
    send_byte({3'b101, 4'h6, 1'b0}, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    bus_clear_n = 1'b0; wait_c(3);
    bus_clear_n = 1'b1; wait_c(2);
    for (int i = 0; i < 5; i++) clk_bit(1'b0, s);
    clk_bit(1'b1, a);
    check(a == 1'b1, "R9 no ack after clear", {7'd0, a}, 8'h01);
    check(port == 8'h11, "R9 port kept", port, 8'h11);
    i2c_stop();
    i2c_start();
    send_byte({3'b101, 4'h6, 1'b0}, a);
    send_byte(8'h77, a);
    check(a == 1'b0 && port == 8'h77, "R9 new transfer works", port, 8'h77);
    i2c_stop();
  endtask

  initial begin
    wait_c(5);
    t_reset();
    rst_n = 1'b1;
    wait_c(5);
    t_reset();
    t_write();
    t_wrong_addr();
    t_read_snap();
    t_rstart();
    t_bus_clear();
    check(pull_viol == 0, "R10 pull rises only with SCL low", 8'(pull_viol), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule